// File: doc/BRIEF.md
# Horizontal Pixel Zoom and Decimate Unit

This unit sits on the readout path, between the words fetched from the frame store and the bus interface. It scales a pixel stream along the horizontal axis. In one mode it copies each word through unchanged. In two modes it repeats every pixel two or four times. In the fourth mode it drops every second pixel. It works only on the stream, so the stored frame is never written.

The pixel size is selectable. In narrow mode a pixel is one byte, so each 32-bit word carries four pixels. In wide mode a 12-bit pixel sits in a 16-bit half-word, so each 32-bit word carries two pixels. In both zoom modes the repeated unit is one pixel container: a byte or a half-word. In zoom by 2 the output volume is exactly twice the input, and in zoom by 4 it is four times the input. Whoever programs the transfer length must scale it by the same factor.

Pixels inside a word are taken lowest lane first, and output words are filled lowest lane first. The mode and the pixel size are taken from the control inputs only while the unit holds no data. The unit also flags a configuration error when clipping and padding are both requested.

Top module: `hzoom_unit`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and cfg_err is 0.
- R2: With mode_sel = 0 (copy), each accepted input word appears once on the output, unchanged and in order.
- R3: With mode_sel = 1 (zoom by 2) and pix16 = 0, each input word gives two output words. Output word k holds input byte (4k+j)>>1 in byte lane j, for k = 0..1 and j = 0..3. Lane j is bits 8j+7:8j.
- R4: With mode_sel = 2 (zoom by 4) and pix16 = 0, each input word gives four output words. Output word k holds input byte (4k+j)>>2 in byte lane j, for k = 0..3.
- R5: With pix16 = 1, the repeated unit is the 16-bit half-word. For zoom by 2, output word k holds input half-word (2k+h)>>1 in half lane h. For zoom by 4, output word k holds input half-word (2k+h)>>2 in half lane h. Half lane h is bits 16h+15:16h.
- R6: With mode_sel = 3 (decimate), input words are consumed in pairs (a, b), and no output appears after the first word of a pair.
  - With pix16 = 0, each pair gives {b[23:16], b[7:0], a[23:16], a[7:0]}.
  - With pix16 = 1, each pair gives {b[15:0], a[15:0]}.
- R7: While a zoomed word still has output beats to send besides its final one, in_ready stays 0.
- R8: While out_valid is 1 and out_ready is 0, out_valid and out_data hold their values into the next cycle.
- R9: mode_sel and pix16 are sampled only while the unit is idle. Idle means it holds no output word and no half-finished decimation pair. A change made at any other time is ignored until the unit is idle again.
- R10: cfg_err is 1 one cycle after clip_en and pad_en are both 1 on a clock edge. It is 0 one cycle after any edge where they are not both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Requested scaling mode: 0 copy, 1 zoom by 2, 2 zoom by 4, 3 decimate |
| pix16 | input | 1 | 1 selects 16-bit pixel containers, 0 selects byte pixels |
| clip_en | input | 1 | Clipping requested by the output formatter |
| pad_en | input | 1 | Padding requested by the output formatter |
| cfg_err | output | 1 | Registered flag: clipping and padding requested together |
| in_data | input | 32 | Word read from the frame store |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Unit accepts in_data on this edge |
| out_data | output | 32 | Scaled word toward the bus |
| out_valid | output | 1 | out_data is valid |
| out_ready | input | 1 | Downstream accepts out_data on this edge |

## Verification
The bench runs every mode with both pixel sizes against a model that expands or thins a pixel list and then repacks it. A unit that reversed the lane order, repeated words where it should repeat pixels, or kept the odd pixels when decimating would miscompare on the first word.

The bench changes the mode while a zoomed word is only partly sent, and again between the two halves of a decimation pair. A unit that switched modes early would cut the zoom burst short, or would emit the lone first half as a copy.

Other runs stall the output at random and probe in_ready in the middle of a burst. These runs catch words that change under back-pressure and inputs that are accepted too early and then overwritten.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int WORD_W     = 32;
  localparam int BYTE_LANES = WORD_W / 8;
  localparam int HALF_LANES = WORD_W / 16;
  localparam int KEEP_W     = WORD_W / 2;
  localparam int BEAT_W     = 2;

  typedef enum logic [1:0] {
    MODE_COPY  = 2'd0,
    MODE_ZOOM2 = 2'd1,
    MODE_ZOOM4 = 2'd2,
    MODE_DECIM = 2'd3
  } hz_mode_e;

  // log2 of the repeat factor for a mode
  function automatic logic [1:0] flog_of(input hz_mode_e m);
    case (m)
      MODE_ZOOM2: flog_of = 2'd1;
      MODE_ZOOM4: flog_of = 2'd2;
      default:    flog_of = 2'd0;
    endcase
  endfunction

  // index of the final output beat for a repeat factor
  function automatic logic [BEAT_W-1:0] beat_limit(input logic [1:0] flog);
    case (flog)
      2'd1:    beat_limit = 2'd1;
      2'd2:    beat_limit = 2'd3;
      default: beat_limit = 2'd0;
    endcase
  endfunction

  // output beat idx of a word whose pixels are repeated 2**flog times
  function automatic logic [WORD_W-1:0] zoom_word(input logic [WORD_W-1:0] w,
                                                  input logic [BEAT_W-1:0] idx,
                                                  input logic [1:0] flog,
                                                  input logic p16);
    logic [WORD_W-1:0] r;
    int src;
    r = '0;
    if (p16) begin
      for (int h = 0; h < HALF_LANES; h++) begin
        src = ((int'(idx) * HALF_LANES + h) >> flog) & (HALF_LANES - 1);
        r[h*16 +: 16] = w[src*16 +: 16];
      end
    end else begin
      for (int b = 0; b < BYTE_LANES; b++) begin
        src = ((int'(idx) * BYTE_LANES + b) >> flog) & (BYTE_LANES - 1);
        r[b*8 +: 8] = w[src*8 +: 8];
      end
    end
    return r;
  endfunction

  // pixels kept from one word when dropping every second pixel
  function automatic logic [KEEP_W-1:0] decim_keep(input logic [WORD_W-1:0] w,
                                                   input logic p16);
    logic [KEEP_W-1:0] k;
    k = '0;
    if (p16) begin
      k = w[KEEP_W-1:0];
    end else begin
      for (int b = 0; b < BYTE_LANES / 2; b++)
        k[b*8 +: 8] = w[(2*b)*8 +: 8];
    end
    return k;
  endfunction
endpackage

// File: rtl/hz_mode_ctl.sv
module hz_mode_ctl
  import hz_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  hz_mode_e mode_req,
  input  logic     p16_req,
  input  logic     idle,
  input  logic     clip_en,
  input  logic     pad_en,
  output hz_mode_e eff_mode,
  output logic     eff_p16,
  output logic     cfg_err
);
  hz_mode_e cur_mode_q;
  logic     cur_p16_q;
  logic     cfg_err_q;

  // requests pass straight through only while nothing is held
  assign eff_mode = idle ? mode_req : cur_mode_q;
  assign eff_p16  = idle ? p16_req  : cur_p16_q;
  assign cfg_err  = cfg_err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mode_q <= MODE_COPY;
      cur_p16_q  <= 1'b0;
      cfg_err_q  <= 1'b0;
    end else begin
      cur_mode_q <= eff_mode;
      cur_p16_q  <= eff_p16;
      cfg_err_q  <= clip_en & pad_en;
    end
  end
endmodule

// File: rtl/hz_decim_pack.sv
module hz_decim_pack
  import hz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] word,
  input  logic              p16,
  output logic              acc_v,
  output logic              pair_done,
  output logic [WORD_W-1:0] pack_word
);
  logic [KEEP_W-1:0] acc_q;
  logic              acc_v_q;

  assign acc_v     = acc_v_q;
  assign pair_done = take & acc_v_q;
  assign pack_word = {decim_keep(word, p16), acc_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      acc_v_q <= 1'b0;
    end else if (take) begin
      if (acc_v_q) begin
        acc_v_q <= 1'b0;
      end else begin
        acc_q   <= decim_keep(word, p16);
        acc_v_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hz_rep_stage.sv
module hz_rep_stage
  import hz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [1:0]        load_flog,
  input  logic              load_p16,
  input  logic              out_ready,
  output logic              hold_v,
  output logic              last_beat,
  output logic              out_fire,
  output logic              free,
  output logic [WORD_W-1:0] out_data
);
  logic [WORD_W-1:0] hold_q;
  logic [1:0]        flog_q;
  logic              p16_q;
  logic [BEAT_W-1:0] idx_q;
  logic              hold_v_q;

  assign hold_v    = hold_v_q;
  assign last_beat = hold_v_q & (idx_q == beat_limit(flog_q));
  assign out_fire  = hold_v_q & out_ready;
  assign free      = ~hold_v_q | (last_beat & out_ready);
  assign out_data  = zoom_word(hold_q, idx_q, flog_q, p16_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= '0;
      flog_q   <= 2'd0;
      p16_q    <= 1'b0;
      idx_q    <= '0;
      hold_v_q <= 1'b0;
    end else if (load) begin
      hold_q   <= load_word;
      flog_q   <= load_flog;
      p16_q    <= load_p16;
      idx_q    <= '0;
      hold_v_q <= 1'b1;
    end else if (out_fire) begin
      if (last_beat) hold_v_q <= 1'b0;
      else           idx_q    <= idx_q + 2'd1;
    end
  end
endmodule

// File: rtl/hzoom_unit.sv
module hzoom_unit
  import hz_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_sel,
  input  logic        pix16,
  input  logic        clip_en,
  input  logic        pad_en,
  output logic        cfg_err,
  input  logic [31:0] in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [31:0] out_data,
  output logic        out_valid,
  input  logic        out_ready
);
  hz_mode_e          eff_mode;
  logic              eff_p16;
  logic              idle;
  logic              in_fire;
  logic              out_fire;
  logic              hold_v;
  logic              last_beat;
  logic              rep_free;
  logic              acc_v;
  logic              pair_done;
  logic [WORD_W-1:0] pack_word;
  logic              rep_load;
  logic              decim_take;
  logic [WORD_W-1:0] load_word;
  logic [1:0]        load_flog;

  assign idle       = ~hold_v & ~acc_v;
  assign in_ready   = rep_free;
  assign in_fire    = in_valid & rep_free;
  assign decim_take = in_fire & (eff_mode == MODE_DECIM);
  assign rep_load   = (in_fire & (eff_mode != MODE_DECIM)) | pair_done;
  assign load_word  = pair_done ? pack_word : in_data;
  assign load_flog  = pair_done ? 2'd0 : flog_of(eff_mode);
  assign out_valid  = hold_v;

  hz_mode_ctl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_req (hz_mode_e'(mode_sel)),
    .p16_req  (pix16),
    .idle     (idle),
    .clip_en  (clip_en),
    .pad_en   (pad_en),
    .eff_mode (eff_mode),
    .eff_p16  (eff_p16),
    .cfg_err  (cfg_err)
  );

  hz_decim_pack u_decim (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (decim_take),
    .word      (in_data),
    .p16       (eff_p16),
    .acc_v     (acc_v),
    .pair_done (pair_done),
    .pack_word (pack_word)
  );

  hz_rep_stage u_rep (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rep_load),
    .load_word (load_word),
    .load_flog (load_flog),
    .load_p16  (eff_p16),
    .out_ready (out_ready),
    .hold_v    (hold_v),
    .last_beat (last_beat),
    .out_fire  (out_fire),
    .free      (rep_free),
    .out_data  (out_data)
  );
endmodule

// File: rtl/hz_chk.sv
module hz_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic [31:0] out_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic        clip_en,
  input logic        pad_en,
  input logic        cfg_err,
  input logic        idle,
  input logic [1:0]  eff_mode,
  input logic        last_beat,
  input logic        acc_v,
  input logic        in_fire,
  input logic        out_fire
);
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R7
  zoom_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !last_beat |-> !in_ready);

  // R9
  mode_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> eff_mode == $past(eff_mode));

  // R10
  cfg_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clip_en && pad_en |=> cfg_err);

  // R10
  cfg_err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clip_en && pad_en) |=> !cfg_err);

  // R6
  half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && eff_mode == 2'd3 && !acc_v |=> acc_v && !out_valid);

  // R8
  fire_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |-> out_valid);
endmodule

bind hzoom_unit hz_chk u_hz_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .clip_en   (clip_en),
  .pad_en    (pad_en),
  .cfg_err   (cfg_err),
  .idle      (idle),
  .eff_mode  (eff_mode),
  .last_beat (last_beat),
  .acc_v     (acc_v),
  .in_fire   (in_fire),
  .out_fire  (out_fire)
);

// File: tb/test_hzoom_unit.sv
module test_hzoom_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic        pix16 = 1'b0;
  logic        clip_en = 1'b0;
  logic        pad_en = 1'b0;
  logic        cfg_err;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hzoom_unit i_hzoom_unit (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pix16(pix16),
    .clip_en(clip_en), .pad_en(pad_en), .cfg_err(cfg_err),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  // model: list pixels, repeat or thin them, repack lowest lane first
  function automatic void model(input logic [31:0] ins[$], input int mode,
                                input bit p16, output logic [31:0] outs[$]);
    logic [15:0] px[$];
    logic [15:0] sel[$];
    logic [31:0] w;
    int per;
    int rep;
    per = p16 ? 2 : 4;
    rep = (mode == 1) ? 2 : (mode == 2) ? 4 : 1;
    outs = {};
    foreach (ins[i])
      for (int j = 0; j < per; j++)
        px.push_back(p16 ? ins[i][j*16 +: 16] : {8'h00, ins[i][j*8 +: 8]});
    for (int i = 0; i < px.size(); i++) begin
      if (mode == 3) begin
        if (i % 2 == 0) sel.push_back(px[i]);
      end else begin
        for (int r = 0; r < rep; r++) sel.push_back(px[i]);
      end
    end
    for (int i = 0; i + per <= sel.size(); i += per) begin
      w = '0;
      for (int j = 0; j < per; j++)
        if (p16) w[j*16 +: 16] = sel[i+j];
        else     w[j*8 +: 8]   = sel[i+j][7:0];
      outs.push_back(w);
    end
  endfunction

  task automatic drive_word(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drive_all(input logic [31:0] ins[$]);
    foreach (ins[k]) drive_word(ins[k]);
  endtask

  task automatic collect(input string req, input logic [31:0] exp[$], input bit stall);
    int k;
    int cyc;
    k = 0;
    cyc = 0;
    while (k < exp.size()) begin
      @(negedge clk);
      out_ready = stall ? (cyc % 3 != 1) : 1'b1;
      cyc++;
      #1;
      if (out_valid && out_ready) begin
        chk(req, out_data, exp[k]);
        k++;
      end
    end
    @(negedge clk);
    out_ready = 1'b1;
  endtask

  task automatic t_stream(input string req, input int mode, input bit p16,
                          input int n, input int seed, input bit stall);
    logic [31:0] ins[$];
    logic [31:0] exp[$];
    for (int k = 0; k < n; k++)
      ins.push_back((32'h9E37_79B9 * (k + seed + 1)) ^ (32'h0101_0101 * seed));
    model(ins, mode, p16, exp);
    @(negedge clk);
    mode_sel = 2'(mode);
    pix16    = p16;
    fork
      drive_all(ins);
      collect(req, exp, stall);
    join
    repeat (2) @(negedge clk);
    #1;
    chk({req, " no extra output"}, {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
    chk("R1 cfg_err", {31'd0, cfg_err}, 32'd0);
  endtask

  // zoom burst with a mode change part way through
  task automatic t_busy_mode();
    logic [31:0] w;
    logic [31:0] exp[$];
    logic [31:0] one[$];
    w = 32'hA1B2_C3D4;
    @(negedge clk);
    mode_sel  = 2'd2;
    pix16     = 1'b0;
    out_ready = 1'b0;
    drive_word(w);
    mode_sel = 2'd0;
    #1;
    chk("R7 in_ready low mid burst", {31'd0, in_ready}, 32'd0);
    chk("R8 first beat", out_data, 32'hD4D4_D4D4);
    @(negedge clk);
    #1;
    chk("R8 held valid", {31'd0, out_valid}, 32'd1);
    chk("R8 held data", out_data, 32'hD4D4_D4D4);
    one.push_back(w);
    model(one, 2, 0, exp);
    collect("R9 zoom kept after change", exp, 0);
    t_stream("R9 new mode once idle", 0, 0, 2, 7, 0);
  endtask

  // decimate pair split by a mode change request
  task automatic t_half_pair();
    logic [31:0] exp[$];
    @(negedge clk);
    mode_sel = 2'd3;
    pix16    = 1'b0;
    drive_word(32'h4433_2211);
    #1;
    chk("R6 no output on half pair", {31'd0, out_valid}, 32'd0);
    mode_sel = 2'd0;
    exp.push_back(32'h7755_3311);
    fork
      drive_word(32'h8877_6655);
      collect("R9 pair finished in decimate", exp, 0);
    join
  endtask

  task automatic t_cfg();
    @(negedge clk);
    clip_en = 1'b1;
    pad_en  = 1'b1;
    @(negedge clk);
    #1;
    chk("R10 both set", {31'd0, cfg_err}, 32'd1);
    pad_en = 1'b0;
    @(negedge clk);
    #1;
    chk("R10 one set", {31'd0, cfg_err}, 32'd0);
    clip_en = 1'b0;
    pad_en  = 1'b1;
    @(negedge clk);
    #1;
    chk("R10 other set", {31'd0, cfg_err}, 32'd0);
    pad_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_stream("R2 copy", 0, 0, 5, 1, 0);
    t_stream("R8 copy stalled", 0, 0, 6, 2, 1);
    t_stream("R3 zoom2 byte", 1, 0, 4, 3, 0);
    t_stream("R4 zoom4 byte", 2, 0, 3, 4, 1);
    t_stream("R5 zoom2 half", 1, 1, 4, 5, 1);
    t_stream("R5 zoom4 half", 2, 1, 3, 6, 0);
    t_stream("R6 decimate byte", 3, 0, 6, 8, 0);
    t_stream("R6 decimate half", 3, 1, 4, 9, 1);
    t_busy_mode();
    t_half_pair();
    t_cfg();
    done = 1;
    finish_up();
  end
endmodule